// File: doc/BRIEF.md
# SD Card Clock Generator with Gated Output

This block derives the clock for an SD card from the host clock and carries the few control bits that sit next to that clock: the bus-width option and the two soft-reset controls. Software programs it over a simple 16-bit register write bus with a combinational read port. A one-hot byte selects the divisor, and the card clock runs only while two separate enable bits are set. Software sets them in a fixed order to start the clock and clears them in the reverse order to stop it.

All divider and enable changes are taken in at the end of a low phase of the card clock. The card clock therefore never shows a shortened high or low pulse when software retunes or gates it. When the divisor byte is zero, a separate output asks an external pre-divider to pass the undivided host clock. The bus-width flag and the two reset controls are plain register bits driven out to neighbouring logic.

Top module: `sdclk_gen`

## Requirements
- R1: After reset, `card_clk` is low, `ext_div_sel` is 0 and `bus_1bit` is 1. Both reset outputs are 0. Reads return 0x0080 at offset 0x024, 0x80e0 at 0x028, and 0x0000 at 0x138, 0x0e0 and 0x1e0.
- R2: The clock control register at byte offset 0x024 stores bits 8:0 of a write and reads bits 15:9 as zero. Bit 8 is the clock enable and bits 7:0 are the divisor byte.
- R3: If bit k is the highest set bit of the divisor byte, the running card clock has a period of 2^(k+2) host cycles, half high and half low. A zero byte gives a period of 2 host cycles.
- R4: If the divisor byte has several bits set, only the highest set bit sets the divisor.
- R5: The card clock toggles only while both bit 8 of 0x024 and bit 8 of 0x138 are 1. Otherwise it settles low and stays low. To start, software sets bit 8 of 0x024 first and then writes 0x0100 to 0x138. To stop, software clears 0x138 first and then clears bit 8 of 0x024.
- R6: A change of divisor or enable takes effect only at the end of a low phase. Every high phase, and every low phase between two running high phases, lasts exactly half the period of a divisor that was programmed.
- R7: `ext_div_sel` is 1 exactly when the divisor byte of 0x024 is zero.
- R8: The bus option register at 0x028 stores all 16 bits. `bus_1bit` equals its bit 15, where 1 means a 1-bit bus and 0 means a 4-bit bus.
- R9: The soft-reset registers at 0x0e0 (card logic) and 0x1e0 (I/O function logic) store bit 0 only and read bits 15:1 as zero. `sd_rst_n` and `sdio_rst_n` follow the stored bit, where 0 holds reset and 1 releases it.
- R10: Writes to unmapped offsets change no register, and reads of unmapped offsets return 0.
- R11: The clock-and-wait register at 0x138 stores bit 8 only and reads every other bit as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one host cycle |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| card_clk | output | 1 | Divided and gated card clock |
| ext_div_sel | output | 1 | Request for the undivided host clock from the external pre-divider |
| bus_1bit | output | 1 | 1 selects a 1-bit data bus, 0 a 4-bit bus |
| sd_rst_n | output | 1 | Card logic reset, active low |
| sdio_rst_n | output | 1 | I/O function logic reset, active low |

## Verification
The hardest case to reach is a divisor or enable change that lands in the middle of a card clock phase, because the effect appears only later, at a phase boundary. The stimulus waits at the ports for a rising card clock and then writes a new divisor, or clears the wait enable, a few host cycles into that high phase. A monitor measures every completed phase and accepts only the lengths of the old and new divisors. The same monitor measures both phase lengths for every one-hot divisor setting and for several multi-bit patterns, and compares each to the length that the bench computes from the highest set bit.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int DATA_W   = 16;
  localparam int SEL_W    = 8;
  localparam int ENA_BIT  = 8;
  localparam int WAIT_BIT = 8;
  localparam int NARROW_BIT = 15;

  localparam logic [8:0] OFF_CLKCTL = 9'h024;
  localparam logic [8:0] OFF_BUSOPT = 9'h028;
  localparam logic [8:0] OFF_WAIT   = 9'h138;
  localparam logic [8:0] OFF_SDRST  = 9'h0e0;
  localparam logic [8:0] OFF_IORST  = 9'h1e0;

  localparam logic [SEL_W-1:0]  SEL_RESET = 8'h80;
  localparam logic [DATA_W-1:0] OPT_RESET = 16'h80e0;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic              clk_en;
    logic              wait_en;
    logic [DATA_W-1:0] opt;
    logic              sd_rel;
    logic              io_rel;
  } ctl_state_t;
endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
  import sdclk_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctl_state_t        st_o
);
  localparam logic [ADDR_W-1:0] A_CLK = ADDR_W'(OFF_CLKCTL);
  localparam logic [ADDR_W-1:0] A_OPT = ADDR_W'(OFF_BUSOPT);
  localparam logic [ADDR_W-1:0] A_WT  = ADDR_W'(OFF_WAIT);
  localparam logic [ADDR_W-1:0] A_SD  = ADDR_W'(OFF_SDRST);
  localparam logic [ADDR_W-1:0] A_IO  = ADDR_W'(OFF_IORST);

  ctl_state_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q.sel     <= SEL_RESET;
      st_q.clk_en  <= 1'b0;
      st_q.wait_en <= 1'b0;
      st_q.opt     <= OPT_RESET;
      st_q.sd_rel  <= 1'b0;
      st_q.io_rel  <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == A_CLK) begin
        st_q.sel    <= wdata_i[SEL_W-1:0];
        st_q.clk_en <= wdata_i[ENA_BIT];
      end
      if (addr_i == A_OPT) st_q.opt     <= wdata_i;
      if (addr_i == A_WT)  st_q.wait_en <= wdata_i[WAIT_BIT];
      if (addr_i == A_SD)  st_q.sd_rel  <= wdata_i[0];
      if (addr_i == A_IO)  st_q.io_rel  <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CLK) begin
      rdata_o[SEL_W-1:0] = st_q.sel;
      rdata_o[ENA_BIT]   = st_q.clk_en;
    end
    if (addr_i == A_OPT) rdata_o = st_q.opt;
    if (addr_i == A_WT)  rdata_o[WAIT_BIT] = st_q.wait_en;
    if (addr_i == A_SD)  rdata_o[0] = st_q.sd_rel;
    if (addr_i == A_IO)  rdata_o[0] = st_q.io_rel;
  end

  assign st_o = st_q;
endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
  import sdclk_pkg::*;
#(
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sel_i,
  input  logic          run_i,
  output logic          card_clk_o,
  output logic          upd_o,
  output logic          act_run_o,
  output logic [SW:0]   act_half_o
);
  localparam int CNT_W = SW + 1;

  // Half period in host cycles; the highest set bit wins because later
  // iterations overwrite earlier ones.
  function automatic logic [CNT_W-1:0] half_len(input logic [SW-1:0] s);
    logic [CNT_W-1:0] h;
    h = CNT_W'(1);
    for (int i = 0; i < SW; i++) begin
      if (s[i]) h = CNT_W'(1) << (i + 1);
    end
    return h;
  endfunction

  logic [SW-1:0]    act_sel_q;
  logic             act_run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cclk_q;
  logic [CNT_W-1:0] act_half;
  logic             phase_end;
  logic             upd;

  assign act_half  = half_len(act_sel_q);
  assign phase_end = (cnt_q == act_half - CNT_W'(1));
  // Settings are loaded only while the output is low: at the last cycle of
  // a running low phase, or at any cycle once stopped.
  assign upd       = !cclk_q && (!act_run_q || phase_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel_q <= '0;
      act_run_q <= 1'b0;
      cnt_q     <= '0;
      cclk_q    <= 1'b0;
    end else if (upd) begin
      act_sel_q <= sel_i;
      act_run_q <= run_i;
      cnt_q     <= '0;
      cclk_q    <= run_i;
    end else if (cclk_q && phase_end) begin
      cclk_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign card_clk_o = cclk_q;
  assign upd_o      = upd;
  assign act_run_o  = act_run_q;
  assign act_half_o = act_half;
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              card_clk,
  output logic              ext_div_sel,
  output logic              bus_1bit,
  output logic              sd_rst_n,
  output logic              sdio_rst_n
);
  ctl_state_t     st;
  logic           run_req;
  logic           upd_evt;
  logic           act_run;
  logic [SEL_W:0] act_half;

  sdclk_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .rdata_o (bus_rdata),
    .st_o    (st)
  );

  // Both gates must be open: the clock enable and the clock-and-wait bit.
  assign run_req = st.clk_en & st.wait_en;

  sdclk_div #(.SW(SEL_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (st.sel),
    .run_i      (run_req),
    .card_clk_o (card_clk),
    .upd_o      (upd_evt),
    .act_run_o  (act_run),
    .act_half_o (act_half)
  );

  assign ext_div_sel = (st.sel == '0);
  assign bus_1bit    = st.opt[NARROW_BIT];
  assign sd_rst_n    = st.sd_rel;
  assign sdio_rst_n  = st.io_rel;
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
  parameter int HW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          card_clk,
  input logic          upd_evt,
  input logic          act_run,
  input logic          run_req,
  input logic [HW-1:0] act_half
);
  logic [31:0] hi_cnt;
  logic [31:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= card_clk ? hi_cnt + 32'd1 : 32'd0;
      lo_cnt <= card_clk ? 32'd0 : lo_cnt + 32'd1;
    end
  end

  AST_UPD_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |-> !card_clk); // R6

  AST_HIGH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_clk) |-> (hi_cnt == 32'(act_half))); // R3

  AST_LOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(card_clk) && $past(act_run)) |-> (lo_cnt == 32'($past(act_half)))); // R6

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_clk) |-> $past(run_req)); // R5

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_run && !run_req) |=> !card_clk); // R5
endmodule

bind sdclk_gen sdclk_gen_chk #(.HW(sdclk_pkg::SEL_W + 1)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .card_clk (card_clk),
  .upd_evt  (upd_evt),
  .act_run  (act_run),
  .run_req  (run_req),
  .act_half (act_half)
);

// File: tb/sdclk_gen_tb.sv
module sdclk_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        card_clk, ext_div_sel, bus_1bit, sd_rst_n, sdio_rst_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // phase monitor state
  int run_len = 0;
  int last_hi = 0;
  int last_lo = 0;
  int rise_cnt = 0;
  bit prev_lvl = 0;
  bit mon_chk = 0;
  int allow_a = 0;
  int allow_b = 0;

  always #2 clk = ~clk;

  sdclk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .card_clk(card_clk),
    .ext_div_sel(ext_div_sel), .bus_1bit(bus_1bit), .sd_rst_n(sd_rst_n),
    .sdio_rst_n(sdio_rst_n)
  );

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (card_clk == prev_lvl) run_len++;
      else begin
        if (prev_lvl) begin
          last_hi = run_len;
          if (mon_chk) chk("R6 high phase", (run_len == allow_a) || (run_len == allow_b), run_len, allow_a);
        end else begin
          last_lo = run_len;
          rise_cnt++;
          if (mon_chk) chk("R6 low phase", (run_len == allow_a) || (run_len == allow_b), run_len, allow_a);
        end
        run_len = 1;
      end
      prev_lvl = card_clk;
    end
  end

  task automatic wr(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [8:0] a, input logic [15:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata == exp, bus_rdata, exp);
  endtask

  task automatic wait_rises(input int n);
    int r0 = rise_cnt;
    for (int i = 0; i < 8000 && rise_cnt < r0 + n; i++) @(negedge clk);
  endtask

  function automatic int exp_half(input logic [7:0] s);
    for (int b = 7; b >= 0; b--) if (s[b]) return 2 << b;
    return 1;
  endfunction

  task automatic meas_chk(input string tag, input logic [7:0] s);
    int h;
    wr(9'h024, {8'h01, s});
    wait_rises(3);
    h = exp_half(s);
    chk({tag, " high"}, last_hi == h, last_hi, h);
    chk({tag, " low"}, last_lo == h, last_lo, h);
    chk("R7 ext_div_sel", ext_div_sel == (s == 8'h00), ext_div_sel, s == 8'h00);
  endtask

  initial begin : wdog
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      chk("watchdog", 1'b0, 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 card_clk", card_clk == 1'b0, card_clk, 0);
    chk("R1 ext_div_sel", ext_div_sel == 1'b0, ext_div_sel, 0);
    chk("R1 bus_1bit", bus_1bit == 1'b1, bus_1bit, 1);
    chk("R1 resets", {sd_rst_n, sdio_rst_n} == 2'b00, {sd_rst_n, sdio_rst_n}, 0);
    rd_chk("R1 clkctl", 9'h024, 16'h0080);
    rd_chk("R1 busopt", 9'h028, 16'h80e0);
    rd_chk("R1 wait", 9'h138, 16'h0000);
    rd_chk("R1 sdrst", 9'h0e0, 16'h0000);
    rd_chk("R1 iorst", 9'h1e0, 16'h0000);

    // R2 / R11 field widths
    wr(9'h024, 16'hfe5a);
    rd_chk("R2 clkctl mask", 9'h024, 16'h005a);
    wr(9'h138, 16'hffff);
    rd_chk("R11 wait mask", 9'h138, 16'h0100);
    wr(9'h138, 16'h0000);

    // R5 one gate open is not enough
    wr(9'h024, 16'h0102);
    r = rise_cnt;
    repeat (100) @(negedge clk);
    chk("R5 enable only", rise_cnt == r && !card_clk, rise_cnt - r, 0);
    wr(9'h024, 16'h0002);
    wr(9'h138, 16'h0100);
    r = rise_cnt;
    repeat (100) @(negedge clk);
    chk("R5 wait only", rise_cnt == r && !card_clk, rise_cnt - r, 0);
    // R5 start order: enable first, then wait
    wr(9'h138, 16'h0000);
    wr(9'h024, 16'h0102);
    wr(9'h138, 16'h0100);
    r = rise_cnt;
    repeat (100) @(negedge clk);
    chk("R5 start", rise_cnt > r, rise_cnt - r, 1);

    // R3 sweep of every one-hot divisor and zero
    meas_chk("R3 sel zero", 8'h00);
    for (int k = 0; k < 8; k++) meas_chk("R3 one-hot", 8'(1 << k));
    // R4 multi-bit patterns
    meas_chk("R4 pattern", 8'h03);
    meas_chk("R4 pattern", 8'h5a);
    meas_chk("R4 pattern", 8'hff);
    meas_chk("R4 pattern", 8'h81);

    // R6 divisor change in the middle of a high phase
    wr(9'h024, 16'h0104);
    wait_rises(2);
    repeat (3) @(negedge clk);
    allow_a = 8; allow_b = 2; mon_chk = 1;
    wr(9'h024, 16'h0101);
    repeat (80) @(negedge clk);
    mon_chk = 0;
    chk("R6 new high", last_hi == 2, last_hi, 2);
    chk("R6 new low", last_lo == 2, last_lo, 2);

    // R6 / R5 stop order in the middle of a high phase
    wr(9'h024, 16'h0104);
    wait_rises(2);
    repeat (2) @(negedge clk);
    allow_a = 8; allow_b = 8; mon_chk = 1;
    wr(9'h138, 16'h0000);
    wr(9'h024, 16'h0004);
    repeat (40) @(negedge clk);
    mon_chk = 0;
    chk("R6 last high full", last_hi == 8, last_hi, 8);
    r = rise_cnt;
    repeat (200) @(negedge clk);
    chk("R5 stopped", rise_cnt == r && !card_clk, rise_cnt - r, 0);

    // R8 bus width
    wr(9'h028, 16'h00e0);
    chk("R8 4-bit", bus_1bit == 1'b0, bus_1bit, 0);
    rd_chk("R8 readback", 9'h028, 16'h00e0);
    wr(9'h028, 16'h80e0);
    chk("R8 1-bit", bus_1bit == 1'b1, bus_1bit, 1);

    // R9 soft resets
    wr(9'h0e0, 16'hffff);
    chk("R9 sd release", sd_rst_n == 1'b1 && sdio_rst_n == 1'b0, {sd_rst_n, sdio_rst_n}, 2'b10);
    rd_chk("R9 sd mask", 9'h0e0, 16'h0001);
    wr(9'h1e0, 16'h0001);
    chk("R9 io release", sdio_rst_n == 1'b1, sdio_rst_n, 1);
    wr(9'h0e0, 16'h0000);
    chk("R9 sd hold", sd_rst_n == 1'b0, sd_rst_n, 0);

    // R10 unmapped access
    wr(9'h030, 16'h1234);
    rd_chk("R10 unmapped read", 9'h030, 16'h0000);
    wr(9'h124, 16'hffff);
    rd_chk("R10 clkctl kept", 9'h024, 16'h0004);
    rd_chk("R10 wait kept", 9'h138, 16'h0000);
    chk("R10 no clock", !card_clk, card_clk, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule